// File: doc/BRIEF.md
# Two-Level Microcoded Control Sequencer

This block is the control unit for a single-bus, multi-cycle datapath. It is built from two lookup tables rather than random logic. The current microstep sits in a binary-coded register. The step number and the instruction opcode together form the address into a first table. That table returns three things: the next step, a flag asking to wait for memory, and a short selector code. A second table expands the selector into the full word of datapath control lines. The datapath itself lives outside the block. It applies the control word during the cycle and raises `mem_rdy` when a memory read has completed.

Every instruction starts with the same three-step fetch. The next step is a dispatch step whose action depends on the opcode. After that come the execute steps. Every instruction ends by moving PC+1 into the PC and returning to step 0.

Control word bit map (bit: meaning):
- bits 0 to 4 are the bus drivers: 0 PC, 1 MDR, 2 Y, 3 Ra, 4 Rb.
- bits 5 to 10 are the register loads: 5 MAR, 6 IR, 7 X, 8 Y, 9 Rc, 10 PC.
- bit 11 is the memory read strobe.
- bit 12 sets the ALU to add.
- bit 13 drives the constant 1 onto ALU input A.

Top module: `useq_ctrl`

## Requirements
- R1: `rst_n` is an active-low asynchronous reset. While it is low, the microstep is 0 and `ctrl` is 0x0021 (PC onto the bus, MAR load). After it is released, sequencing starts from step 0.
- R2: Every instruction fetch runs through three steps. Step 0 emits 0x0021, step 1 emits 0x0800 (read), and step 2 emits 0x0042 (MDR to IR). The block then enters dispatch step 3.
- R3: Steps 1 and 8 are read steps. In a read step with `mem_rdy` low, the step holds and 0x0800 repeats. The step advances at the first clock edge where `mem_rdy` is high.
- R4: Opcode 0 (add) emits, from the dispatch step onward: 0x0088, 0x1110, 0x0204, 0x3101, 0x0404. These are Ra to X, Rb with add into Y, Y to Rc, PC+1 into Y, and Y to PC.
- R5: Opcode 1 (load) emits, from the dispatch step onward: 0x0030 (Rb to MAR), then read step 8 (0x0800), then 0x0202 (MDR to Rc), 0x3101 and 0x0404.
- R6: Opcodes 2 to 7 emit 0x3101 at dispatch and then 0x0404. Any step that emits 0x0404 (PC load) is followed by step 0.
- R7: The opcode is used only in dispatch step 3. At every other step, its value changes neither `ctrl` nor `nxt_state`.
- R8: `mem_rdy` has no effect outside the read steps.
- R9: `nxt_state` is the 4-bit binary number of the step the block enters at the next clock edge. Steps are numbered as follows: 0 to 2 are fetch, 3 is dispatch, 4 is the add step, 5 writes Rc, 6 increments the PC, 7 writes the PC, 8 is the load read, and 9 writes the load result. During a hold, `nxt_state` equals the current step.
- R10: No control word asserts more than one of the bus-driver bits 0 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| opcode | input | 3 | Opcode field of the instruction register (register specifiers excluded) |
| mem_rdy | input | 1 | High when the pending memory read has delivered its data |
| ctrl | output | 14 | Datapath control word for the current cycle |
| nxt_state | output | 4 | Microstep entered at the next clock edge |

## Verification
The assertions assume three things about the inputs. First, `rst_n` rises in step with the clock. Second, `opcode` and `mem_rdy` are settled before each rising edge. Third, the memory eventually answers, so a hold ends. The stimulus changes inputs only at falling edges, and it always raises `mem_rdy` after a bounded number of wait cycles. Outside the dispatch step and the read steps, the stimulus deliberately scrambles the opcode and `mem_rdy` to show that they are ignored there.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int CTRL_W = 14;
  typedef logic [CTRL_W-1:0] ctrl_t;

  // Control-word bit positions
  localparam int B_DRV_PC  = 0;
  localparam int B_DRV_MDR = 1;
  localparam int B_DRV_Y   = 2;
  localparam int B_DRV_RA  = 3;
  localparam int B_DRV_RB  = 4;
  localparam int B_LD_MAR  = 5;
  localparam int B_LD_IR   = 6;
  localparam int B_LD_X    = 7;
  localparam int B_LD_Y    = 8;
  localparam int B_LD_RC   = 9;
  localparam int B_LD_PC   = 10;
  localparam int B_MEM_RD  = 11;
  localparam int B_ALU_ADD = 12;
  localparam int B_A_ONE   = 13;
  localparam int N_DRV     = 5;

  // Narrow selector codes (first table output)
  localparam int SEL_NONE     = 0;
  localparam int SEL_PC2MAR   = 1;
  localparam int SEL_MEMRD    = 2;
  localparam int SEL_MDR2IR   = 3;
  localparam int SEL_RA2X     = 4;
  localparam int SEL_RBADD2Y  = 5;
  localparam int SEL_Y2RC     = 6;
  localparam int SEL_PCINC2Y  = 7;
  localparam int SEL_Y2PC     = 8;
  localparam int SEL_RB2MAR   = 9;
  localparam int SEL_MDR2RC   = 10;

  // Microstep numbers
  localparam int ST_FETCH = 0;
  localparam int ST_READ  = 1;
  localparam int ST_LDIR  = 2;
  localparam int ST_DISP  = 3;
  localparam int ST_SUM   = 4;
  localparam int ST_RCWR  = 5;
  localparam int ST_INC   = 6;
  localparam int ST_PCWR  = 7;
  localparam int ST_LDRD  = 8;
  localparam int ST_LDWB  = 9;
  localparam int N_STEPS  = 10;

  // Opcode values
  localparam int OP_ADD  = 0;
  localparam int OP_LOAD = 1;
endpackage

// File: rtl/useq_seq_rom.sv
module useq_seq_rom #(
  parameter int SW    = 4,
  parameter int OPW   = 3,
  parameter int SEL_W = 4
) (
  input  logic [SW-1:0]    state,
  input  logic [OPW-1:0]   opcode,
  output logic [SW-1:0]    nxt_raw,
  output logic             wait_req,
  output logic [SEL_W-1:0] sel
);
  import useq_pkg::*;

  localparam int AW    = SW + OPW;
  localparam int DEPTH = 1 << AW;
  localparam int UW    = SW + 1 + SEL_W;

  function automatic logic [UW-1:0] entry(input int st, input int op);
    int   nx;
    int   sl;
    logic w;
    nx = ST_FETCH;
    sl = SEL_NONE;
    w  = 1'b0;
    case (st)
      ST_FETCH: begin nx = ST_READ;  sl = SEL_PC2MAR; end
      ST_READ:  begin nx = ST_LDIR;  sl = SEL_MEMRD;  w = 1'b1; end
      ST_LDIR:  begin nx = ST_DISP;  sl = SEL_MDR2IR; end
      ST_DISP: begin
        if (op == OP_ADD) begin
          nx = ST_SUM;  sl = SEL_RA2X;
        end else if (op == OP_LOAD) begin
          nx = ST_LDRD; sl = SEL_RB2MAR;
        end else begin
          nx = ST_PCWR; sl = SEL_PCINC2Y;
        end
      end
      ST_SUM:   begin nx = ST_RCWR;  sl = SEL_RBADD2Y; end
      ST_RCWR:  begin nx = ST_INC;   sl = SEL_Y2RC;    end
      ST_INC:   begin nx = ST_PCWR;  sl = SEL_PCINC2Y; end
      ST_PCWR:  begin nx = ST_FETCH; sl = SEL_Y2PC;    end
      ST_LDRD:  begin nx = ST_LDWB;  sl = SEL_MEMRD;  w = 1'b1; end
      ST_LDWB:  begin nx = ST_INC;   sl = SEL_MDR2RC;  end
      default:  begin nx = ST_FETCH; sl = SEL_NONE;    end
    endcase
    return {SW'(nx), w, SEL_W'(sl)};
  endfunction

  logic [UW-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    localparam logic [UW-1:0] WORD = entry(g >> OPW, g & ((1 << OPW) - 1));
    assign rom[g] = WORD;
  end

  logic [AW-1:0] addr;
  logic [UW-1:0] word;

  always_comb begin
    addr = {state, opcode};
    word = rom[addr];
    {nxt_raw, wait_req, sel} = word;
  end
endmodule

// File: rtl/useq_ctl_rom.sv
module useq_ctl_rom #(
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0]       sel,
  output useq_pkg::ctrl_t        ctrl
);
  import useq_pkg::*;

  localparam int DEPTH = 1 << SEL_W;

  function automatic ctrl_t expand(input int s);
    ctrl_t c;
    c = '0;
    case (s)
      SEL_PC2MAR:  begin c[B_DRV_PC] = 1'b1; c[B_LD_MAR] = 1'b1; end
      SEL_MEMRD:   c[B_MEM_RD] = 1'b1;
      SEL_MDR2IR:  begin c[B_DRV_MDR] = 1'b1; c[B_LD_IR] = 1'b1; end
      SEL_RA2X:    begin c[B_DRV_RA] = 1'b1; c[B_LD_X] = 1'b1; end
      SEL_RBADD2Y: begin c[B_DRV_RB] = 1'b1; c[B_ALU_ADD] = 1'b1; c[B_LD_Y] = 1'b1; end
      SEL_Y2RC:    begin c[B_DRV_Y] = 1'b1; c[B_LD_RC] = 1'b1; end
      SEL_PCINC2Y: begin
        c[B_DRV_PC] = 1'b1; c[B_A_ONE] = 1'b1; c[B_ALU_ADD] = 1'b1; c[B_LD_Y] = 1'b1;
      end
      SEL_Y2PC:    begin c[B_DRV_Y] = 1'b1; c[B_LD_PC] = 1'b1; end
      SEL_RB2MAR:  begin c[B_DRV_RB] = 1'b1; c[B_LD_MAR] = 1'b1; end
      SEL_MDR2RC:  begin c[B_DRV_MDR] = 1'b1; c[B_LD_RC] = 1'b1; end
      default:     c = '0;
    endcase
    return c;
  endfunction

  ctrl_t rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    localparam ctrl_t WORD = expand(g);
    assign rom[g] = WORD;
  end

  assign ctrl = rom[sel];
endmodule

// File: rtl/useq_state.sv
module useq_state #(
  parameter int N_STATES = 10,
  parameter int SW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] nxt_raw,
  input  logic          wait_req,
  input  logic          mem_rdy,
  output logic [SW-1:0] cur,
  output logic [SW-1:0] nxt
);
  logic advance;

  always_comb begin
    advance = !wait_req || mem_rdy;
    nxt     = advance ? nxt_raw : cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (advance) begin
      cur <= nxt_raw;
    end
  end

  // R3: a wait request without memory-ready freezes the step
  p_hold_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && !mem_rdy) |=> $stable(cur));

  // R9: the step register never leaves the defined range
  p_state_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cur) < N_STATES));
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter  int OPW      = 3,
  parameter  int SEL_W    = 4,
  parameter  int N_STATES = useq_pkg::N_STEPS,
  localparam int SW       = $clog2(N_STATES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [OPW-1:0]              opcode,
  input  logic                        mem_rdy,
  output logic [useq_pkg::CTRL_W-1:0] ctrl,
  output logic [SW-1:0]               nxt_state
);
  import useq_pkg::*;

  logic [SW-1:0]    cur_state;
  logic [SW-1:0]    nxt_raw;
  logic             wait_req;
  logic [SEL_W-1:0] sel;

  useq_state #(.N_STATES(N_STATES), .SW(SW)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .nxt_raw  (nxt_raw),
    .wait_req (wait_req),
    .mem_rdy  (mem_rdy),
    .cur      (cur_state),
    .nxt      (nxt_state)
  );

  useq_seq_rom #(.SW(SW), .OPW(OPW), .SEL_W(SEL_W)) u_seq (
    .state    (cur_state),
    .opcode   (opcode),
    .nxt_raw  (nxt_raw),
    .wait_req (wait_req),
    .sel      (sel)
  );

  useq_ctl_rom #(.SEL_W(SEL_W)) u_ctl (
    .sel  (sel),
    .ctrl (ctrl)
  );

  // R10: a single driver at most on the shared bus
  p_one_driver_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl[N_DRV-1:0]));

  // R2: loading the IR is followed by the dispatch step
  p_ir_dispatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[B_LD_IR] |=> (32'(cur_state) == ST_DISP));

  // R6: writing the PC ends the instruction and returns to fetch
  p_pc_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[B_LD_PC] |=> (cur_state == '0));

  // R3: the read strobe persists while memory is not ready
  p_read_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[B_MEM_RD] && !mem_rdy) |=> ctrl[B_MEM_RD]);
endmodule

// File: tb/sim_useq_ctrl.sv
module sim_useq_ctrl;
  localparam int CLK_PERIOD = 10;

  localparam logic [13:0] C_PC2MAR  = 14'h0021;
  localparam logic [13:0] C_MEMRD   = 14'h0800;
  localparam logic [13:0] C_MDR2IR  = 14'h0042;
  localparam logic [13:0] C_RA2X    = 14'h0088;
  localparam logic [13:0] C_RBADD   = 14'h1110;
  localparam logic [13:0] C_Y2RC    = 14'h0204;
  localparam logic [13:0] C_PCINC   = 14'h3101;
  localparam logic [13:0] C_Y2PC    = 14'h0404;
  localparam logic [13:0] C_RB2MAR  = 14'h0030;
  localparam logic [13:0] C_MDR2RC  = 14'h0202;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  opcode = 3'd0;
  logic        mem_rdy = 1'b0;
  wire  [13:0] ctrl;
  wire  [3:0]  nxt_state;

  useq_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .mem_rdy   (mem_rdy),
    .ctrl      (ctrl),
    .nxt_state (nxt_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  int m_state = 0;
  bit done = 1'b0;

  // Behavioural reference: expected word and successor per step
  task automatic model(input int s, input int op, input bit rdy,
                       output logic [13:0] c, output int n);
    case (s)
      0: begin c = C_PC2MAR; n = 1; end
      1: begin c = C_MEMRD;  n = rdy ? 2 : 1; end
      2: begin c = C_MDR2IR; n = 3; end
      3: begin
        if (op == 0)      begin c = C_RA2X;   n = 4; end
        else if (op == 1) begin c = C_RB2MAR; n = 8; end
        else              begin c = C_PCINC;  n = 7; end
      end
      4: begin c = C_RBADD;  n = 5; end
      5: begin c = C_Y2RC;   n = 6; end
      6: begin c = C_PCINC;  n = 7; end
      7: begin c = C_Y2PC;   n = 0; end
      8: begin c = C_MEMRD;  n = rdy ? 9 : 8; end
      9: begin c = C_MDR2RC; n = 6; end
      default: begin c = 14'h0; n = 0; end
    endcase
  endtask

  task automatic check(input string tag, input string what,
                       input logic [13:0] act, input logic [13:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h (step %0d)", tag, what, act, exp, m_state);
    end
  endtask

  task automatic apply(input logic [2:0] op, input bit rdy, input string tag, input bit wait_edge);
    logic [13:0] ec;
    int en;
    if (wait_edge) @(negedge clk);
    opcode = op;
    mem_rdy = rdy;
    #1;
    model(m_state, int'(op), rdy, ec, en);
    check(tag, "ctrl", ctrl, ec);
    check("R9", "nxt_state", {10'd0, nxt_state}, 14'(en));
    check("R10", "bus drivers onehot0", {13'd0, $onehot0(ctrl[4:0])}, 14'd1);
    m_state = en;
  endtask

  task automatic run_instr(input logic [2:0] op, input int w1, input int w2,
                           input string tag, input bit scr_op, input bit scr_rdy);
    int c1 = w1;
    int c2 = w2;
    do begin
      logic [2:0] o;
      bit r;
      string t;
      o = (scr_op && m_state != 3) ? 3'($urandom) : op;
      if (m_state == 1) begin
        r = (c1 == 0);
        if (c1 > 0) c1--;
      end else if (m_state == 8) begin
        r = (c2 == 0);
        if (c2 > 0) c2--;
      end else begin
        r = scr_rdy ? 1'($urandom) : 1'b0;
      end
      if (m_state == 1 || m_state == 8) t = "R3";
      else if (m_state == 0 || m_state == 2) t = "R2";
      else t = tag;
      apply(o, r, t, 1'b1);
    end while (m_state != 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      #1;
      check("R1", "ctrl in reset", ctrl, C_PC2MAR);
      check("R1", "nxt_state in reset", {10'd0, nxt_state}, 14'd1);
    end
    @(negedge clk);
    rst_n = 1'b1;
    m_state = 0;
    apply(3'd0, 1'b1, "R1", 1'b0);

    run_instr(3'd0, 0, 0, "R4", 1'b0, 1'b0);
    run_instr(3'd0, 3, 0, "R4", 1'b0, 1'b0);
    run_instr(3'd1, 0, 0, "R5", 1'b0, 1'b0);
    run_instr(3'd1, 2, 4, "R5", 1'b0, 1'b0);
    for (int k = 2; k < 8; k++) run_instr(3'(k), 1, 0, "R6", 1'b0, 1'b0);
    run_instr(3'd0, 2, 0, "R7", 1'b1, 1'b0);
    run_instr(3'd1, 1, 1, "R7", 1'b1, 1'b0);
    run_instr(3'd0, 0, 0, "R8", 1'b0, 1'b1);
    run_instr(3'd1, 2, 2, "R8", 1'b0, 1'b1);

    // R1: reset in the middle of an add
    for (int k = 0; k < 5; k++) apply(3'd0, 1'b1, "R4", 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "ctrl after mid-run reset", ctrl, C_PC2MAR);
    m_state = 0;
    @(negedge clk);
    rst_n = 1'b1;
    apply(3'd0, 1'b0, "R1", 1'b0);
    run_instr(3'd0, 0, 0, "R4", 1'b0, 1'b0);

    for (int k = 0; k < 30; k++) begin
      logic [2:0] o;
      o = 3'($urandom);
      run_instr(o, int'($urandom % 4), int'($urandom % 4), "R7", 1'b1, 1'b1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule